// File: doc/BRIEF.md
# Latched/Registered Bidirectional Bus Transceiver

This block joins two 18-bit buses, A and B, through two storage paths, one in each direction. Each path holds its own word and can work in one of three ways. It can pass data straight through while its latch enable is high. It can hold the last word while the latch enable is low. It can take a new word on a rising edge of its bus clock, and a clock enable gates those edges. An active-low output enable decides whether the path drives its far bus. Each bus leaves the block as a data vector and a drive-enable bit, so the pad ring can build the tri-state buffers.

The block runs on one fast system clock. The latch enable, the bus clock and the output enable are sampled on each system clock edge. A bus clock edge counts as rising when the bus clock is sampled high and was sampled low on the edge before. A flag goes high when both output enables are active at once, because that would drive both buses together.

Top module: `bus_xcvr_top`

## Requirements
- R1: If a direction's latch enable is sampled high on a clock edge, that direction's output data after the edge equals the input data sampled on that edge.
- R2: If the latch enable is sampled low and there is no enabled rising bus clock edge (and no recall under R9), the output data keeps its value.
- R3: If the latch enable is low, the clock enable is low (0), and the bus clock is sampled high after being sampled low on the edge before, the input data is stored and appears on the output after that edge. This also holds when the latch enable falls on that same edge.
- R4: While the clock enable is high (1), rising bus clock edges store nothing and the output keeps its level.
- R5: A low (0) output enable sampled on an edge sets that direction's drive-enable after the edge, and a high (1) one clears it. The output data does not depend on the output enable.
- R6: The B-to-A path (B input to A output, with its own four controls) behaves the same as the A-to-B path and is independent of it.
- R7: Both paths are 18 bits wide and non-inverting. Every bit moves to the same bit position unchanged.
- R8: While reset is high on a clock edge, both drive-enables, both stored words and the conflict flag become 0.
- R9: If the latch enable falls (sampled high, then low) while the bus clock was sampled high on the previous edge, and there is no capture under R3, the output takes the word stored at the latest enabled rising edge (zero after reset). Edges stored while transparent count too. If the bus clock was low, the last transparent word is kept.
- R10: The conflict flag is 1 after an edge on which both output enables are sampled low, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Data received from bus A |
| b_in | input | 18 | Data received from bus B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (high = transparent) |
| ab_bclk | input | 1 | A-to-B bus clock |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_bclk | input | 1 | B-to-A bus clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | 18 | Data to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| a_out | output | 18 | Data to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| bus_conflict | output | 1 | Both directions enabled at once |

## Verification
Two events can land on the same system clock edge: the latch enable falling and an enabled rising edge of the bus clock. The bench sets this up by raising the bus clock on the edge where it drops the latch enable, with a distinct word on the input. The new word must show on the output, not the last transparent word. A second case drops the latch enable while the bus clock is already high. Here the output must fall back to the word stored at the earlier rising edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int DATA_W = 18;
    localparam int N_DIR  = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_PASS,
        OP_CAPTURE,
        OP_RECALL
    } store_op_e;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic bclk;
        logic ce_n;
    } dir_ctrl_t;

    // Priority: transparent, then clocked capture, then recall on latch close.
    function automatic store_op_e pick_op(input logic le, input logic rise_en,
                                          input logic close_hi);
        if (le)            return OP_PASS;
        else if (rise_en)  return OP_CAPTURE;
        else if (close_hi) return OP_RECALL;
        else               return OP_HOLD;
    endfunction
endpackage

// File: rtl/xcvr_sampler.sv
module xcvr_sampler
    import xcvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dir_ctrl_t ctrl,
    output store_op_e op,
    output logic      rise_en,
    output logic      drive_en
);
    logic bclk_q;
    logic le_q;
    logic close_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q   <= 1'b0;
            le_q     <= 1'b0;
            drive_en <= 1'b0;
        end else begin
            bclk_q   <= ctrl.bclk;
            le_q     <= ctrl.le;
            drive_en <= ~ctrl.oe_n;
        end
    end

    always_comb begin
        rise_en  = ctrl.bclk & ~bclk_q & ~ctrl.ce_n;
        close_hi = le_q & ~ctrl.le & bclk_q;
        op       = pick_op(ctrl.le, rise_en, close_hi);
    end

    // R5: drive enable follows the inverted output enable one edge later
    p_drive_follows_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (drive_en == !$past(ctrl.oe_n)));

    // R4: a blocked clock never yields a capture
    p_ce_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl.ce_n |-> (op != OP_CAPTURE));
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  store_op_e    op,
    input  logic         cap_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            cap_q <= '0;
        end else begin
            if (cap_en) cap_q <= din;
            unique case (op)
                OP_PASS:    dout <= din;
                OP_CAPTURE: dout <= din;
                OP_RECALL:  dout <= cap_q;
                default:    dout <= dout;
            endcase
        end
    end

    // R2: no store operation, no output change
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op == OP_HOLD)) |-> $stable(dout));
endmodule

// File: rtl/xcvr_conflict.sv
module xcvr_conflict (
    input  logic clk,
    input  logic rst,
    input  logic ab_oe_n,
    input  logic ba_oe_n,
    output logic conflict
);
    always_ff @(posedge clk) begin
        if (rst) conflict <= 1'b0;
        else     conflict <= ~ab_oe_n & ~ba_oe_n;
    end
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top
    import xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_bclk,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_bclk,
    input  logic         ba_ce_n,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic         bus_conflict
);
    dir_ctrl_t    ctrl [N_DIR];
    logic [W-1:0] din  [N_DIR];
    logic [W-1:0] dout [N_DIR];
    logic         den  [N_DIR];

    assign ctrl[DIR_AB] = '{oe_n: ab_oe_n, le: ab_le, bclk: ab_bclk, ce_n: ab_ce_n};
    assign ctrl[DIR_BA] = '{oe_n: ba_oe_n, le: ba_le, bclk: ba_bclk, ce_n: ba_ce_n};
    assign din[DIR_AB]  = a_in;
    assign din[DIR_BA]  = b_in;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        store_op_e op;
        logic      rise_en;

        xcvr_sampler u_samp (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (ctrl[d]),
            .op       (op),
            .rise_en  (rise_en),
            .drive_en (den[d])
        );

        xcvr_store #(.W(W)) u_store (
            .clk    (clk),
            .rst    (rst),
            .op     (op),
            .cap_en (rise_en),
            .din    (din[d]),
            .dout   (dout[d])
        );
    end

    xcvr_conflict u_conf (
        .clk      (clk),
        .rst      (rst),
        .ab_oe_n  (ab_oe_n),
        .ba_oe_n  (ba_oe_n),
        .conflict (bus_conflict)
    );

    assign b_out = dout[DIR_AB];
    assign b_oe  = den[DIR_AB];
    assign a_out = dout[DIR_BA];
    assign a_oe  = den[DIR_BA];

    // R1: transparent A-to-B path copies the sampled input
    p_pass_ab_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ab_le)) |-> (b_out == $past(a_in)));

    // R6: same for B-to-A
    p_pass_ba_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ba_le)) |-> (a_out == $past(b_in)));

    // R10: conflict flag matches both drive enables
    p_conflict_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bus_conflict == (a_oe && b_oe)));

    // R8: reset leaves everything quiet
    p_reset_quiet_r8: assert property (@(posedge clk)
        $past(rst) |-> (!a_oe && !b_oe && !bus_conflict && a_out == '0 && b_out == '0));
endmodule

// File: tb/bus_xcvr_top_test.sv
module bus_xcvr_top_test;
    localparam int W = 18;
    localparam int NV = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_bclk = 1'b0, ab_ce_n = 1'b0;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_bclk = 1'b0, ba_ce_n = 1'b0;
    logic [W-1:0] b_out, a_out;
    logic b_oe, a_oe, bus_conflict;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bus_xcvr_top #(.W(W)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_bclk(ab_bclk), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_bclk(ba_bclk), .ba_ce_n(ba_ce_n),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
        .bus_conflict(bus_conflict)
    );

    // {le, bclk, ce_n, din, expected b_out}
    localparam logic [2*W+2:0] VECS [NV] = '{
        {1'b1, 1'b0, 1'b0, 18'h15555, 18'h15555}, // R1 R7
        {1'b1, 1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA}, // R1 R7
        {1'b0, 1'b0, 1'b0, 18'h00001, 18'h2AAAA}, // R9 close with clock low
        {1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h2AAAA}, // R2
        {1'b0, 1'b1, 1'b0, 18'h12345, 18'h12345}, // R3
        {1'b0, 1'b1, 1'b0, 18'h00F0F, 18'h12345}, // R2 clock stays high
        {1'b0, 1'b0, 1'b0, 18'h0F0F0, 18'h12345}, // R2 falling clock
        {1'b0, 1'b1, 1'b1, 18'h3C3C3, 18'h12345}, // R4
        {1'b0, 1'b0, 1'b1, 18'h3C3C3, 18'h12345}, // R4
        {1'b0, 1'b1, 1'b0, 18'h00ABC, 18'h00ABC}, // R3
        {1'b1, 1'b1, 1'b0, 18'h11111, 18'h11111}, // R1
        {1'b0, 1'b1, 1'b0, 18'h22222, 18'h00ABC}, // R9 close with clock high
        {1'b0, 1'b0, 1'b0, 18'h00000, 18'h00ABC}  // R2
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R8 reset state
        check("R8 b_oe", {31'd0, b_oe}, 32'd0);
        check("R8 a_oe", {31'd0, a_oe}, 32'd0);
        check("R8 b_out", {14'd0, b_out}, 32'd0);
        check("R8 a_out", {14'd0, a_out}, 32'd0);
        check("R8 conflict", {31'd0, bus_conflict}, 32'd0);
        rst = 1'b0;
        ab_oe_n = 1'b0;

        for (int i = 0; i < NV; i++) begin
            ab_le   = VECS[i][2*W+2];
            ab_bclk = VECS[i][2*W+1];
            ab_ce_n = VECS[i][2*W];
            a_in    = VECS[i][2*W-1:W];
            step();
            check($sformatf("R1/R2/R3/R4/R9 vector %0d", i), {14'd0, b_out}, {14'd0, VECS[i][W-1:0]});
        end
        check("R5 b_oe on", {31'd0, b_oe}, 32'd1);
        check("R6 a_out untouched", {14'd0, a_out}, 32'd0);

        // R5: disabling drive leaves data alone
        ab_oe_n = 1'b1;
        step();
        check("R5 b_oe off", {31'd0, b_oe}, 32'd0);
        check("R5 data kept", {14'd0, b_out}, 32'h00ABC);

        // Same-edge: latch closes while an enabled rising edge arrives (R3)
        ab_le = 1'b1; ab_bclk = 1'b0; a_in = 18'h01234;
        step();
        check("R1 pass", {14'd0, b_out}, 32'h01234);
        ab_le = 1'b0; ab_bclk = 1'b1; a_in = 18'h35A5A;
        step();
        check("R3 capture on close", {14'd0, b_out}, 32'h35A5A);

        // R6: B-to-A path, transparent then clocked, A-to-B unaffected
        ba_le = 1'b1; b_in = 18'h0BEEF; ba_oe_n = 1'b0;
        step();
        check("R6 pass", {14'd0, a_out}, 32'h0BEEF);
        check("R6 a_oe", {31'd0, a_oe}, 32'd1);
        check("R6 b_out kept", {14'd0, b_out}, 32'h35A5A);
        ba_le = 1'b0; b_in = 18'h20001;
        step();
        check("R6 hold", {14'd0, a_out}, 32'h0BEEF);
        ba_bclk = 1'b1;
        step();
        check("R6 R7 capture", {14'd0, a_out}, 32'h20001);

        // R10: both enables low
        ab_oe_n = 1'b0;
        step();
        check("R10 conflict on", {31'd0, bus_conflict}, 32'd1);
        ba_oe_n = 1'b1;
        step();
        check("R10 conflict off", {31'd0, bus_conflict}, 32'd0);
        check("R5 a_oe off", {31'd0, a_oe}, 32'd0);

        // R8: reset mid-run
        ba_oe_n = 1'b0;
        rst = 1'b1;
        step();
        check("R8 b_out cleared", {14'd0, b_out}, 32'd0);
        check("R8 a_out cleared", {14'd0, a_out}, 32'd0);
        check("R8 oe cleared", {30'd0, a_oe, b_oe}, 32'd0);
        check("R8 conflict cleared", {31'd0, bus_conflict}, 32'd0);

        // R9 after reset: recall yields zero
        rst = 1'b0; ab_le = 1'b1; ab_bclk = 1'b1; ab_ce_n = 1'b1; a_in = 18'h3FFFF;
        step();
        check("R1 after reset", {14'd0, b_out}, 32'h3FFFF);
        ab_le = 1'b0;
        step();
        check("R9 recall zero", {14'd0, b_out}, 32'd0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule